// File: doc/BRIEF.md
# Line interface mode controller

This block is the digital control core of a subscriber line interface. Each clock it takes a three-bit line-state command and turns it into the effective line state, a ring-signal enable and an alarm flag. It also steers one of three already-synchronised detector flags (loop current, ground key, ring trip) onto a single active-low detect output, and it passes the battery-select and uncommitted-switch controls through to the line circuit.

The block also runs the ring-trip sequence. While ringing is commanded and the ring-trip detector fires, a trip latch is set. From then on the detect output is held asserted, the ring signal is gated off and the line is forced to forward active. The latch is cleared only when the external command code changes. Re-issuing the same code does not clear it, and neither does any activity on the detectors. All outputs are registered, so each follows its inputs one clock later.

Top module: `line_mode_ctrl`

## Requirements
- R1: Command codes 000 (standby), 001 (forward active), 011 (reverse active), 100 (ringing), 101 (forward loopback), 110 (tip open) and 111 (power denial) appear unchanged on `eff_mode` one clock after they are applied, provided no trip is latched.
- R2: The spare code 010 is treated as standby. `eff_mode` reads 000 and `ring_en` stays 0.
- R3: Outside ringing and loopback, with no trip latched, `det_n` is the inverse of `hook_off` when `det_sel` is 1 and the inverse of `gnd_key` when `det_sel` is 0.
- R4: While ringing is commanded and no trip is latched, `det_sel` and the other detectors have no effect, and `det_n` is the inverse of `ring_trip`.
- R5: If `ring_trip` is 1 while 100 is commanded, and the command is the same as on the previous clock, then from the next clock `det_n` is 0, `ring_en` is 0 and `eff_mode` is 001.
- R6: A latched trip persists, whatever the detector inputs and `det_sel` do, for as long as the command code is unchanged.
- R7: A change of the command code clears the trip latch. A change in the same clock as a trip indication takes priority, and the trip is latched only on a later clock with the same code.
- R8: `bat_hi` follows `bat_hi_in` one clock later in every mode, including through a ring trip.
- R9: `sw_on` is the inverse of `sw_ctl_n` one clock later. The switch is on when the control is low.
- R10: `alarm` is 1 exactly when the effective state is forward loopback, and in that state `det_n` is 0.
- R11: `ring_en` is 1 only while the effective state is ringing and no trip is latched.
- R12: During reset, and after it, the outputs read `eff_mode`=000, `ring_en`=0, `det_n`=1, `alarm`=0, `bat_hi`=0 and `sw_on`=0. The trip latch is clear and the stored command is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cmd | input | 3 | Commanded line state |
| det_sel | input | 1 | Detector choice: 1 loop current, 0 ground key |
| bat_hi_in | input | 1 | Battery select request, 1 = high battery |
| sw_ctl_n | input | 1 | Uncommitted switch control, active low |
| hook_off | input | 1 | Synchronised loop-current (off-hook) flag |
| gnd_key | input | 1 | Synchronised ground-key flag |
| ring_trip | input | 1 | Synchronised ring-trip flag |
| eff_mode | output | 3 | Effective line state |
| ring_en | output | 1 | Ring signal input enable |
| bat_hi | output | 1 | Battery select to line, 1 = high |
| sw_on | output | 1 | Uncommitted switch on |
| det_n | output | 1 | Detect output, active low |
| alarm | output | 1 | Loopback alarm flag |

## Verification
The bench targets the ordering at the trip latch. In one case the command changes into ringing in the same clock that `ring_trip` is high. A design that let the set win would latch at once and kill `ring_en`, when the output should instead show the raw trip on `det_n` for one clock. Other cases re-issue the same command, which a design clearing on any write would wrongly accept as a clear. They also drop `ring_trip` and toggle `hook_off` and `det_sel` while the latch is held, which a design without a true latch would follow, letting `det_n` rise. Further checks make sure the battery select survives a trip rather than falling back to low battery, and that the spare code never leaks out as an effective state.

// File: rtl/line_mode_pkg.sv
package line_mode_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      LM_STBY  = 3'b000,
      LM_FWD   = 3'b001,
      LM_SPARE = 3'b010,
      LM_REV   = 3'b011,
      LM_RING  = 3'b100,
      LM_LOOP  = 3'b101,
      LM_TOPEN = 3'b110,
      LM_PDENY = 3'b111
   } line_mode_e;

   // spare code folds onto standby
   function automatic line_mode_e fold_mode(input logic [MODE_W-1:0] code);
      line_mode_e m;
      m = line_mode_e'(code);
      if (m == LM_SPARE) m = LM_STBY;
      return m;
   endfunction
endpackage

// File: rtl/lim_trip_latch.sv
module lim_trip_latch
   import line_mode_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_cmd,
   input  logic              ring_trip,
   output logic              trip_nxt,
   output logic              trip_q
);
   logic [MODE_W-1:0] cmd_q;
   logic              cmd_chg;
   logic              trip_set;

   assign cmd_chg  = (mode_cmd != cmd_q);
   assign trip_set = (line_mode_e'(mode_cmd) == LM_RING) && ring_trip;
   // a command change outranks a new trip indication
   assign trip_nxt = cmd_chg ? 1'b0 : (trip_q | trip_set);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         trip_q <= 1'b0;
      end else begin
         cmd_q  <= mode_cmd;
         trip_q <= trip_nxt;
      end
   end
endmodule

// File: rtl/lim_mode_decode.sv
module lim_mode_decode
   import line_mode_pkg::*;
(
   input  logic [MODE_W-1:0] mode_cmd,
   input  logic              trip,
   output logic [MODE_W-1:0] eff_mode,
   output logic              ring_en,
   output logic              alarm
);
   line_mode_e eff;

   always_comb begin
      if (trip) eff = LM_FWD;
      else      eff = fold_mode(mode_cmd);
   end

   assign eff_mode = eff;
   assign ring_en  = (eff == LM_RING);
   assign alarm    = (eff == LM_LOOP);
endmodule

// File: rtl/lim_detect_sel.sv
module lim_detect_sel
   import line_mode_pkg::*;
#(
   parameter int DET_ACTIVE_LOW = 1
) (
   input  logic [MODE_W-1:0] mode_cmd,
   input  logic              trip,
   input  logic              det_sel,
   input  logic              hook_off,
   input  logic              gnd_key,
   input  logic              ring_trip,
   output logic              det_out
);
   logic event_on;

   always_comb begin
      if (trip)
         event_on = 1'b1;
      else begin
         unique case (line_mode_e'(mode_cmd))
            LM_RING: event_on = ring_trip;
            LM_LOOP: event_on = 1'b1;
            default: event_on = det_sel ? hook_off : gnd_key;
         endcase
      end
   end

   generate
      if (DET_ACTIVE_LOW != 0) begin : g_low
         assign det_out = ~event_on;
      end else begin : g_high
         assign det_out = event_on;
      end
   endgenerate
endmodule

// File: rtl/line_mode_ctrl.sv
module line_mode_ctrl
   import line_mode_pkg::*;
#(
   parameter int REG_OUT        = 1,
   parameter int DET_ACTIVE_LOW = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_cmd,
   input  logic              det_sel,
   input  logic              bat_hi_in,
   input  logic              sw_ctl_n,
   input  logic              hook_off,
   input  logic              gnd_key,
   input  logic              ring_trip,
   output logic [2:0]        eff_mode,
   output logic              ring_en,
   output logic              bat_hi,
   output logic              sw_on,
   output logic              det_n,
   output logic              alarm
);
   localparam logic DET_IDLE = (DET_ACTIVE_LOW != 0) ? 1'b1 : 1'b0;

   generate
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("line_mode_ctrl: REG_OUT must be 0 or 1");
      end
      if (DET_ACTIVE_LOW != 0 && DET_ACTIVE_LOW != 1) begin : g_bad_pol
         $error("line_mode_ctrl: DET_ACTIVE_LOW must be 0 or 1");
      end
      if (MODE_W != 3) begin : g_bad_w
         $error("line_mode_ctrl: command width must be 3");
      end
   endgenerate

   logic              trip_nxt;
   logic              trip_lat;
   logic [MODE_W-1:0] eff_c;
   logic              ring_c;
   logic              alarm_c;
   logic              det_c;

   lim_trip_latch u_trip (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_cmd  (mode_cmd),
      .ring_trip (ring_trip),
      .trip_nxt  (trip_nxt),
      .trip_q    (trip_lat)
   );

   lim_mode_decode u_dec (
      .mode_cmd (mode_cmd),
      .trip     (trip_nxt),
      .eff_mode (eff_c),
      .ring_en  (ring_c),
      .alarm    (alarm_c)
   );

   lim_detect_sel #(.DET_ACTIVE_LOW(DET_ACTIVE_LOW)) u_det (
      .mode_cmd  (mode_cmd),
      .trip      (trip_nxt),
      .det_sel   (det_sel),
      .hook_off  (hook_off),
      .gnd_key   (gnd_key),
      .ring_trip (ring_trip),
      .det_out   (det_c)
   );

   generate
      if (REG_OUT == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               eff_mode <= LM_STBY;
               ring_en  <= 1'b0;
               bat_hi   <= 1'b0;
               sw_on    <= 1'b0;
               det_n    <= DET_IDLE;
               alarm    <= 1'b0;
            end else begin
               eff_mode <= eff_c;
               ring_en  <= ring_c;
               bat_hi   <= bat_hi_in;
               sw_on    <= ~sw_ctl_n;
               det_n    <= det_c;
               alarm    <= alarm_c;
            end
         end
      end else begin : g_comb
         assign eff_mode = eff_c;
         assign ring_en  = ring_c;
         assign bat_hi   = bat_hi_in;
         assign sw_on    = ~sw_ctl_n;
         assign det_n    = det_c;
         assign alarm    = alarm_c;
      end
   endgenerate
endmodule

// File: rtl/line_mode_ctrl_chk.sv
module line_mode_ctrl_chk #(
   parameter int REG_OUT        = 1,
   parameter int DET_ACTIVE_LOW = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_cmd,
   input logic       ring_trip,
   input logic       bat_hi_in,
   input logic       sw_ctl_n,
   input logic [2:0] eff_mode,
   input logic       ring_en,
   input logic       bat_hi,
   input logic       sw_on,
   input logic       det_n,
   input logic       alarm,
   input logic       trip
);
   localparam logic DET_ON = (DET_ACTIVE_LOW != 0) ? 1'b0 : 1'b1;

   logic [2:0] prev_cmd;
   logic       same_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_cmd <= 3'b000;
      else        prev_cmd <= mode_cmd;
   end
   assign same_cmd = (mode_cmd == prev_cmd);

   generate
      if (REG_OUT == 1) begin : g_chk
         p_ring_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ring_en |-> (eff_mode == 3'b100 && !trip));

         p_alarm_loop_r10: assert property (@(posedge clk) disable iff (!rst_n)
            alarm |-> (eff_mode == 3'b101 && det_n == DET_ON));

         p_no_spare_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_cmd == 3'b010) |=> (eff_mode != 3'b010 && !ring_en));

         p_trip_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_cmd == 3'b100 && ring_trip && same_cmd) |=>
               (eff_mode == 3'b001 && !ring_en && det_n == DET_ON));

         p_trip_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (trip && same_cmd) |=> trip);

         p_trip_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!same_cmd) |=> !trip);

         p_bat_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (bat_hi == $past(bat_hi_in)));

         p_sw_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (sw_on != $past(sw_ctl_n)));
      end
   endgenerate
endmodule

bind line_mode_ctrl line_mode_ctrl_chk #(
   .REG_OUT        (REG_OUT),
   .DET_ACTIVE_LOW (DET_ACTIVE_LOW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_cmd  (mode_cmd),
   .ring_trip (ring_trip),
   .bat_hi_in (bat_hi_in),
   .sw_ctl_n  (sw_ctl_n),
   .eff_mode  (eff_mode),
   .ring_en   (ring_en),
   .bat_hi    (bat_hi),
   .sw_on     (sw_on),
   .det_n     (det_n),
   .alarm     (alarm),
   .trip      (trip_lat)
);

// File: tb/line_mode_ctrl_tb_top.sv
module line_mode_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_cmd = 3'b000;
   logic       det_sel = 1'b0;
   logic       bat_hi_in = 1'b0;
   logic       sw_ctl_n = 1'b1;
   logic       hook_off = 1'b0;
   logic       gnd_key = 1'b0;
   logic       ring_trip = 1'b0;
   logic [2:0] eff_mode;
   logic       ring_en, bat_hi, sw_on, det_n, alarm;

   always #10 clk = ~clk;

   line_mode_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .mode_cmd(mode_cmd), .det_sel(det_sel),
      .bat_hi_in(bat_hi_in), .sw_ctl_n(sw_ctl_n), .hook_off(hook_off),
      .gnd_key(gnd_key), .ring_trip(ring_trip), .eff_mode(eff_mode),
      .ring_en(ring_en), .bat_hi(bat_hi), .sw_on(sw_on), .det_n(det_n),
      .alarm(alarm)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    cmp_on   = 1'b0;
   bit    finished = 1'b0;
   string phase    = "R12";

   // behavioural reference model
   int m_prev = 0;
   bit m_trip = 0;
   int x_mode = 0;
   bit x_ring = 0, x_bat = 0, x_sw = 0, x_det = 1, x_alarm = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prev = 0; m_trip = 0;
         x_mode = 0; x_ring = 0; x_bat = 0; x_sw = 0; x_det = 1; x_alarm = 0;
      end else begin
         int  cmd;
         bit  ev;
         cmd = int'(mode_cmd);
         if (cmd != m_prev)                  m_trip = 0;
         else if (cmd == 4 && ring_trip)     m_trip = 1;
         m_prev = cmd;
         if (m_trip)        x_mode = 1;
         else if (cmd == 2) x_mode = 0;
         else               x_mode = cmd;
         x_ring  = (x_mode == 4);
         x_alarm = (x_mode == 5);
         if (m_trip)         ev = 1;
         else if (cmd == 4)  ev = ring_trip;
         else if (cmd == 5)  ev = 1;
         else                ev = det_sel ? hook_off : gnd_key;
         x_det = !ev;
         x_bat = bat_hi_in;
         x_sw  = !sw_ctl_n;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s [%s] %s actual=%0d expected=%0d at %0t", req, phase, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R1",  "eff_mode", int'(eff_mode), x_mode);
         chk("R11", "ring_en",  int'(ring_en),  int'(x_ring));
         chk("R3",  "det_n",    int'(det_n),    int'(x_det));
         chk("R10", "alarm",    int'(alarm),    int'(x_alarm));
         chk("R8",  "bat_hi",   int'(bat_hi),   int'(x_bat));
         chk("R9",  "sw_on",    int'(sw_on),    int'(x_sw));
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R12: reset values held while reset is asserted
      step(3);
      bat_hi_in = 1'b1; sw_ctl_n = 1'b0; mode_cmd = 3'b100; ring_trip = 1'b1;
      step(2);
      chk("R12", "reset eff_mode", int'(eff_mode), 0);
      chk("R12", "reset ring_en",  int'(ring_en),  0);
      chk("R12", "reset det_n",    int'(det_n),    1);
      chk("R12", "reset alarm",    int'(alarm),    0);
      chk("R12", "reset bat_hi",   int'(bat_hi),   0);
      chk("R12", "reset sw_on",    int'(sw_on),    0);
      mode_cmd = 3'b000; ring_trip = 1'b0; bat_hi_in = 1'b0; sw_ctl_n = 1'b1;
      step(1);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      step(2);

      // R1 / R2: every code with both selector values
      phase = "R1";
      for (int c = 0; c < 8; c++) begin
         if (c == 2) phase = "R2"; else phase = "R1";
         mode_cmd = 3'(c); det_sel = 1'b0; step(2);
         det_sel = 1'b1; step(2);
      end

      // R3: detector steering in forward active and tip open
      phase = "R3";
      mode_cmd = 3'b001;
      for (int k = 0; k < 8; k++) begin
         det_sel = k[0]; hook_off = k[1]; gnd_key = k[2]; step(1);
      end
      mode_cmd = 3'b110;
      for (int k = 0; k < 8; k++) begin
         det_sel = k[2]; hook_off = k[0]; gnd_key = k[1]; step(1);
      end
      hook_off = 0; gnd_key = 0;

      // R4: ringing ignores selector and other detectors
      phase = "R4";
      mode_cmd = 3'b100; step(2);
      for (int k = 0; k < 8; k++) begin
         det_sel = k[0]; hook_off = k[1]; gnd_key = k[2]; step(1);
      end
      chk("R4", "ringing det_n idle", int'(det_n), 1);
      chk("R4", "ringing ring_en", int'(ring_en), 1);

      // R5 / R8: trip with high battery commanded
      phase = "R5";
      bat_hi_in = 1'b1; step(1);
      ring_trip = 1'b1; step(1);
      chk("R5", "trip det_n", int'(det_n), 0);
      chk("R5", "trip eff_mode", int'(eff_mode), 1);
      chk("R5", "trip ring_en", int'(ring_en), 0);
      chk("R8", "battery kept through trip", int'(bat_hi), 1);

      // R6: latch holds while detectors move
      phase = "R6";
      ring_trip = 1'b0;
      for (int k = 0; k < 8; k++) begin
         det_sel = k[0]; hook_off = k[1]; gnd_key = k[2]; step(1);
      end
      mode_cmd = 3'b100; step(3); // same code re-issued
      chk("R6", "held det_n", int'(det_n), 0);
      chk("R6", "held eff_mode", int'(eff_mode), 1);

      // R7: code change clears; change with simultaneous trip
      phase = "R7";
      mode_cmd = 3'b001; step(1);
      mode_cmd = 3'b100; step(2);
      chk("R7", "cleared ring_en", int'(ring_en), 1);
      mode_cmd = 3'b001; step(1);
      mode_cmd = 3'b100; ring_trip = 1'b1; step(1);
      chk("R7", "change wins ring_en", int'(ring_en), 1);
      chk("R7", "change wins det_n", int'(det_n), 0);
      step(1);
      chk("R7", "trip after change", int'(ring_en), 0);
      ring_trip = 1'b0; mode_cmd = 3'b000; step(2);

      // R9 / R10: switch control and loopback alarm
      phase = "R10";
      mode_cmd = 3'b101; sw_ctl_n = 1'b0; det_sel = 1'b1; hook_off = 1'b0; step(2);
      chk("R10", "loop alarm", int'(alarm), 1);
      chk("R10", "loop det_n", int'(det_n), 0);
      chk("R9", "switch on", int'(sw_on), 1);
      sw_ctl_n = 1'b1; mode_cmd = 3'b011; step(2);
      chk("R10", "alarm off", int'(alarm), 0);

      // mixed stimulus compared every clock
      phase = "mixed";
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(7) == 0) mode_cmd = 3'($urandom_range(7));
         ring_trip = ($urandom_range(5) == 0);
         det_sel   = 1'($urandom_range(1));
         hook_off  = 1'($urandom_range(1));
         gnd_key   = 1'($urandom_range(1));
         bat_hi_in = 1'($urandom_range(1));
         sw_ctl_n  = 1'($urandom_range(1));
         step(1);
      end
      step(2);
      finish_run();
   end
endmodule